// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block gathers interrupt requests from a parameterised set of maskable sources and decides, on every clock, whether the CPU should be interrupted and by which source. Each source owns a small control register. The register holds a request-pending flag and a priority level whose width is a parameter (3 bits by default, levels 0 to 7). A hardware request pulse on a source sets its pending flag. The flag is cleared in two ways: the CPU acknowledges that source, or software writes a zero to it.

Acceptance is gated by a global enable input and by the processor's current priority level, which the CPU supplies as an input. A source can win only if four things hold: the enable is high, its flag is pending, its level is non-zero, and its level is strictly above the processor level. Among the sources that qualify, the highest level wins, and a tie goes to the lower source index. The winner's index and level are presented on registered outputs together with the interrupt line.

A write port updates one source's level and may clear its pending flag. A combinational read port returns any source's flag and level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A `src_req[i]` high at a rising edge makes source i's pending flag 1 after that edge, as seen on `rd_pend` with `rd_idx = i`.
- R2: A write (`wr_en = 1`) to source `wr_idx` loads `wr_lvl` into its level. `wr_pend = 0` clears its pending flag. `wr_pend = 1` leaves the flag unchanged, and so never sets a flag that was 0.
- R3: When a hardware request and a software clear hit the same source at the same edge, the flag ends at 1.
- R4: `ack = 1` at an edge while `irq_out = 1` clears only the flag of the source shown on `irq_idx`, unless that source also requests at the same edge. `ack` while `irq_out = 0` changes no flag.
- R5: `int_en = 0` at an edge forces `irq_out = 0` after that edge.
- R6: A source at level 0 is never presented, whatever the state of the other inputs.
- R7: A source qualifies only if its level is strictly greater than `cpu_ipl`. With `cpu_ipl = 7` nothing is presented, and with `cpu_ipl = 0` every level from 1 to 7 qualifies.
- R8: Among qualifying sources the highest level wins, and a tie goes to the lowest index.
- R9: The outputs `irq_out`, `irq_idx` and `irq_lvl` are registered. After each edge they reflect the flags and levels as updated at that edge, together with `int_en` and `cpu_ipl` sampled at that edge. `irq_idx` and `irq_lvl` are 0 when `irq_out = 0`.
- R10: During and right after reset, every flag and level is 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | N_SRC | Per-source hardware request, sampled at each edge |
| int_en | input | 1 | Global maskable interrupt enable |
| cpu_ipl | input | LVL_W | Current processor priority level |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Source selected for the write |
| wr_pend | input | 1 | Pending value written (0 clears, 1 keeps) |
| wr_lvl | input | LVL_W | Level value written |
| rd_idx | input | IDX_W | Source selected for readback |
| rd_pend | output | 1 | Pending flag of source `rd_idx` |
| rd_lvl | output | LVL_W | Level of source `rd_idx` |
| ack | input | 1 | CPU acknowledge of the presented interrupt |
| irq_out | output | 1 | Interrupt request to the CPU |
| irq_idx | output | IDX_W | Index of the presented source |
| irq_lvl | output | LVL_W | Level of the presented source |

## Verification
The hardest states to reach are edges where several updates collide on one source. One case is a request pulse arriving at the same edge as an acknowledge of that source. Another is a request arriving at the same edge as a software clear of it. A third is an acknowledge that arrives while the line is low. The directed part of the bench steers the presented winner onto a chosen source and then fires these pairs on purpose. After that, a long random phase with dense request, write and acknowledge traffic reproduces such coincidences many times. A cycle-accurate model in the bench checks every edge of the random phase.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int DEF_N_SRC = 8;
   localparam int DEF_LVL_W = 3;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
   parameter int LVL_W = irq_pkg::DEF_LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr_sel,
   input  logic             wr_pend,
   input  logic [LVL_W-1:0] wr_lvl,
   input  logic             ack_clr,
   output logic             pend_q,
   output logic [LVL_W-1:0] lvl_q,
   output logic             pend_d,
   output logic [LVL_W-1:0] lvl_d
);
   logic sw_clr;

   always_comb begin
      sw_clr = wr_sel & ~wr_pend;
      // hardware request has priority over both clear paths
      pend_d = req | (pend_q & ~sw_clr & ~ack_clr);
      lvl_d  = wr_sel ? wr_lvl : lvl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         lvl_q  <= '0;
      end else begin
         pend_q <= pend_d;
         lvl_q  <= lvl_d;
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N_SRC = irq_pkg::DEF_N_SRC,
   parameter int LVL_W = irq_pkg::DEF_LVL_W,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0]            pend,
   input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
   input  logic                        en,
   input  logic [LVL_W-1:0]            ipl,
   output logic                        win_vld,
   output logic [IDX_W-1:0]            win_idx,
   output logic [LVL_W-1:0]            win_lvl
);
   logic [N_SRC-1:0] cand;

   always_comb begin
      for (int i = 0; i < N_SRC; i++)
         cand[i] = en & pend[i] & (lvl[i] > ipl);
   end

   // descending scan with >= so equal levels settle on the lower index
   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (cand[i] && lvl[i] >= win_lvl) begin
            win_vld = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl[i];
         end
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int N_SRC = irq_pkg::DEF_N_SRC,
   parameter int LVL_W = irq_pkg::DEF_LVL_W,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic             int_en,
   input  logic [LVL_W-1:0] cpu_ipl,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_pend,
   input  logic [LVL_W-1:0] wr_lvl,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_pend,
   output logic [LVL_W-1:0] rd_lvl,
   input  logic             ack,
   output logic             irq_out,
   output logic [IDX_W-1:0] irq_idx,
   output logic [LVL_W-1:0] irq_lvl
);
   generate
      if (N_SRC < 2) begin : g_bad_n
         $error("irq_prio_ctrl: N_SRC must be at least 2");
      end
      if (LVL_W < 1 || LVL_W > 8) begin : g_bad_w
         $error("irq_prio_ctrl: LVL_W must lie in 1..8");
      end
   endgenerate

   logic [N_SRC-1:0]            pend_q, pend_d;
   logic [N_SRC-1:0][LVL_W-1:0] lvl_q, lvl_d;
   logic                        win_vld;
   logic [IDX_W-1:0]            win_idx;
   logic [LVL_W-1:0]            win_lvl;

   genvar gi;
   generate
      for (gi = 0; gi < N_SRC; gi++) begin : g_slot
         logic sel;
         logic aclr;
         assign sel  = wr_en & (wr_idx == IDX_W'(gi));
         assign aclr = ack & irq_out & (irq_idx == IDX_W'(gi));
         irq_src_slot #(.LVL_W(LVL_W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (src_req[gi]),
            .wr_sel  (sel),
            .wr_pend (wr_pend),
            .wr_lvl  (wr_lvl),
            .ack_clr (aclr),
            .pend_q  (pend_q[gi]),
            .lvl_q   (lvl_q[gi]),
            .pend_d  (pend_d[gi]),
            .lvl_d   (lvl_d[gi])
         );
      end
   endgenerate

   // arbitrate on next-state so the registered result matches stored state
   irq_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) pick_i (
      .pend    (pend_d),
      .lvl     (lvl_d),
      .en      (int_en),
      .ipl     (cpu_ipl),
      .win_vld (win_vld),
      .win_idx (win_idx),
      .win_lvl (win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out <= 1'b0;
         irq_idx <= '0;
         irq_lvl <= '0;
      end else begin
         irq_out <= win_vld;
         irq_idx <= win_idx;
         irq_lvl <= win_lvl;
      end
   end

   assign rd_pend = pend_q[rd_idx];
   assign rd_lvl  = lvl_q[rd_idx];
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int N_SRC = irq_pkg::DEF_N_SRC,
   parameter int LVL_W = irq_pkg::DEF_LVL_W,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] src_req,
   input logic             int_en,
   input logic [LVL_W-1:0] cpu_ipl,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic             wr_pend,
   input logic             ack,
   input logic             irq_out,
   input logic [IDX_W-1:0] irq_idx,
   input logic [LVL_W-1:0] irq_lvl,
   input logic [N_SRC-1:0] pend_q
);
   a_r1_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req != '0) |=> ((pend_q & $past(src_req)) == $past(src_req)));

   a_r2_write_one_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_pend && !pend_q[wr_idx] && !src_req[wr_idx])
      |=> !pend_q[$past(wr_idx)]);

   a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_out && !src_req[irq_idx]) |=> !pend_q[$past(irq_idx)]);

   a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(int_en));

   a_r6_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_lvl != '0));

   a_r7_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_lvl > $past(cpu_ipl)));

   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> (irq_idx == '0 && irq_lvl == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .src_req (src_req),
   .int_en  (int_en),
   .cpu_ipl (cpu_ipl),
   .wr_en   (wr_en),
   .wr_idx  (wr_idx),
   .wr_pend (wr_pend),
   .ack     (ack),
   .irq_out (irq_out),
   .irq_idx (irq_idx),
   .irq_lvl (irq_lvl),
   .pend_q  (pend_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
   localparam int N  = 8;
   localparam int LW = 3;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_req = '0;
   logic          int_en = 1'b1;
   logic [LW-1:0] cpu_ipl = '0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic          wr_pend = 1'b0;
   logic [LW-1:0] wr_lvl = '0;
   logic [IW-1:0] rd_idx = '0;
   logic          rd_pend;
   logic [LW-1:0] rd_lvl;
   logic          ack = 1'b0;
   logic          irq_out;
   logic [IW-1:0] irq_idx;
   logic [LW-1:0] irq_lvl;

   int n_chk = 0;
   int n_err = 0;

   logic          m_pend [N];
   logic [LW-1:0] m_lvl  [N];
   logic          e_irq = 1'b0;
   logic [IW-1:0] e_idx = '0;
   logic [LW-1:0] e_lvl = '0;

   always #10 clk = ~clk;

   irq_prio_ctrl #(.N_SRC(N), .LVL_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .int_en(int_en),
      .cpu_ipl(cpu_ipl), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pend(wr_pend),
      .wr_lvl(wr_lvl), .rd_idx(rd_idx), .rd_pend(rd_pend), .rd_lvl(rd_lvl),
      .ack(ack), .irq_out(irq_out), .irq_idx(irq_idx), .irq_lvl(irq_lvl)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // expected winner: highest level above ipl, lowest index on ties
   function automatic int best_src(logic en, logic [LW-1:0] ipl);
      int b = -1;
      for (int i = 0; i < N; i++)
         if (en && m_pend[i] && m_lvl[i] > ipl && (b < 0 || m_lvl[i] > m_lvl[b]))
            b = i;
      return b;
   endfunction

   task automatic tick();
      int b;
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
         logic sw_clr, a_clr;
         sw_clr = wr_en && wr_idx == IW'(i) && !wr_pend;
         a_clr  = ack && e_irq && e_idx == IW'(i);
         m_pend[i] = src_req[i] | (m_pend[i] & ~sw_clr & ~a_clr);
         if (wr_en && wr_idx == IW'(i)) m_lvl[i] = wr_lvl;
      end
      b = best_src(int_en, cpu_ipl);
      e_irq = (b >= 0);
      e_idx = (b >= 0) ? IW'(b) : '0;
      e_lvl = (b >= 0) ? m_lvl[b] : '0;
      @(negedge clk);
      chk("R9 irq_out", int'(irq_out), int'(e_irq));
      chk("R9 irq_idx", int'(irq_idx), int'(e_idx));
      chk("R9 irq_lvl", int'(irq_lvl), int'(e_lvl));
   endtask

   task automatic idle();
      src_req = '0; wr_en = 1'b0; wr_pend = 1'b0; wr_lvl = '0; wr_idx = '0; ack = 1'b0;
   endtask

   task automatic write(int idx, logic p, int lv);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_pend = p; wr_lvl = LW'(lv);
      tick();
      idle();
   endtask

   task automatic rd(string tag, int idx, int ep, int el);
      rd_idx = IW'(idx);
      #1;
      chk({tag, " rd_pend"}, int'(rd_pend), ep);
      chk({tag, " rd_lvl"}, int'(rd_lvl), el);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h1A5C;
      void'($urandom(seed));
      for (int i = 0; i < N; i++) begin m_pend[i] = 1'b0; m_lvl[i] = '0; end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 irq_out", int'(irq_out), 0);
      for (int i = 0; i < N; i++) rd("R10", i, 0, 0);
      rst_n = 1'b1;
      tick();
      chk("R10 irq_out after release", int'(irq_out), 0);

      // R1 and R6: request on a level-0 source
      src_req[3] = 1'b1; tick(); idle();
      rd("R1", 3, 1, 0);
      chk("R6 level 0 not presented", int'(irq_out), 0);

      // R2: level load keeps pending, write of 1 does not set
      write(3, 1'b1, 5);
      rd("R2 keep", 3, 1, 5);
      chk("R8 single winner idx", int'(irq_idx), 3);
      write(5, 1'b1, 6);
      rd("R2 no set", 5, 0, 6);

      // R7: strict comparison against ipl
      cpu_ipl = 3'd5; tick();
      chk("R7 equal blocked", int'(irq_out), 0);
      cpu_ipl = 3'd4; tick();
      chk("R7 above accepted", int'(irq_out), 1);
      write(3, 1'b1, 7);
      cpu_ipl = 3'd7; tick();
      chk("R7 ipl 7 blocks", int'(irq_out), 0);
      cpu_ipl = 3'd0;
      write(3, 1'b1, 5);

      // R5: global enable
      int_en = 1'b0; tick();
      chk("R5 disabled", int'(irq_out), 0);
      int_en = 1'b1; tick();

      // R8: tie goes to lowest index, higher level wins
      write(2, 1'b1, 5);
      write(6, 1'b1, 5);
      src_req[2] = 1'b1; src_req[6] = 1'b1; tick(); idle();
      chk("R8 tie low index", int'(irq_idx), 2);
      write(6, 1'b1, 6);
      chk("R8 higher level", int'(irq_idx), 6);

      // R4: ack clears only the presented source
      ack = 1'b1; tick(); idle();
      rd("R4 acked", 6, 0, 6);
      rd("R4 other kept", 2, 1, 5);
      rd("R4 other kept", 3, 1, 5);
      chk("R4 next winner", int'(irq_idx), 2);
      ack = 1'b1; src_req[2] = 1'b1; tick(); idle();
      rd("R4 ack with req", 2, 1, 5);
      int_en = 1'b0; tick();
      ack = 1'b1; tick(); idle();
      rd("R4 ack while idle", 2, 1, 5);
      int_en = 1'b1;

      // R3: request beats software clear
      wr_en = 1'b1; wr_idx = 3'd2; wr_pend = 1'b0; wr_lvl = 3'd5; src_req[2] = 1'b1;
      tick(); idle();
      rd("R3 req wins", 2, 1, 5);
      write(2, 1'b0, 5);
      rd("R2 clear", 2, 0, 5);

      // random traffic against the model (R9)
      for (int c = 0; c < 4000; c++) begin
         src_req = ($urandom % 4 == 0) ? N'($urandom) & N'($urandom) : '0;
         int_en  = ($urandom % 8) != 0;
         cpu_ipl = ($urandom % 3 == 0) ? LW'($urandom) : cpu_ipl;
         wr_en   = ($urandom % 5) == 0;
         wr_idx  = IW'($urandom);
         wr_pend = $urandom % 2;
         wr_lvl  = LW'($urandom);
         ack     = ($urandom % 3) == 0;
         tick();
      end
      idle();
      for (int i = 0; i < N; i++) rd("R9 final", i, int'(m_pend[i]), int'(m_lvl[i]));

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule